// File: doc/BRIEF.md
# Factory Bad-Block Table Builder

This engine builds a map of the factory-marked invalid erase blocks of a small-page NAND array. A scan starts on request, for example once after power-up. The engine walks the blocks in ascending order. For each block it reads the spare byte that carries the invalid mark, on the first page and, when needed, on the second page. It records one bit per block. It does not drive the NAND pins. Each byte read goes out as a request on a simple request/acknowledge port, and a lower-level bus engine serves it.

The array has 512 blocks of 16 pages each. A row address is formed as block number times 16 plus page index. The mark sits at column 517, which is offset 5 in the 16-byte spare field that starts at column 512. Any value other than FFh there means the block is bad. Block 0 is guaranteed good, so it is never read. Other logic looks up the table through a combinational query port indexed by block number. A saturating count of bad blocks comes out beside it.

Top module: `bbt_builder`

## Requirements
- R1: A start accepted while idle raises busy_o at the next clock edge. At the same edge it clears every table entry to good (q_bad_o = 0) and resets bad_cnt_o to 0.
- R2: Block 0 is never read, and it reports good whatever its mark holds.
- R3: Reads cover blocks 1 to 511 in ascending order. Each read uses row = block*16 + page, page 0 first and then page 1. Every read carries column 517.
- R4: A page-0 byte other than FFh marks the block bad (table bit 1), and the page-1 read for that block is not issued.
- R5: When the page-0 byte is FFh, the block is read again on page 1. It is marked bad exactly when that byte is not FFh.
- R6: rd_req_o stays high with a stable row and column until rd_ack_i. Each acknowledge consumes exactly one read, and its rd_data_i is taken in that same cycle.
- R7: After the last block is evaluated, done_o is high for exactly one cycle and busy_o falls at the same edge. bad_cnt_o and the table then hold until the next start.
- R8: bad_cnt_o equals the number of blocks marked bad in the current scan, never decreases during a scan, and saturates at its all-ones value.
- R9: A start that arrives while busy has no effect. The scan goes on without restarting, and only one done_o pulse is produced.
- R10: q_bad_o combinationally returns the table bit of the block given on q_blk_i. 1 means bad.
- R11: After reset, busy_o, done_o and rd_req_o are 0, bad_cnt_o is 0, and every query returns good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Scan request, sampled while idle |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse at scan completion |
| rd_req_o | output | 1 | Byte read request |
| rd_row_o | output | 13 | Row (page) address of the read |
| rd_col_o | output | 10 | Column address of the read |
| rd_ack_i | input | 1 | Read served; data valid this cycle |
| rd_data_i | input | 8 | Byte returned with the acknowledge |
| q_blk_i | input | 9 | Block number to look up |
| q_bad_o | output | 1 | Table bit of the looked-up block (1 = bad) |
| bad_cnt_o | output | 10 | Saturating count of bad blocks |

## Verification
The first scan runs over an array with no marks at all. It shows that every block gets both reads and that none is flagged. The second scan uses a mixed pattern: marks only on page 0, marks only on page 1, marks on both pages, a mark on the last block, and a mark planted on block 0. This separates the early-exit path, the second-page path and the block-0 exemption. Mark values such as 00h, FEh and 7Fh are included, so a check of a single bit cannot pass for an FFh comparison. The final scan returns to a clean array after the marked one, and the responder's acknowledge latency changes from scan to scan. Together these show that the table is cleared at each start, that a start arriving mid-scan is ignored, and that the handshake holds across latencies.

// File: rtl/bbt_pkg.sv
package bbt_pkg;
    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_READ = 1'b1
    } walk_st_t;
endpackage

// File: rtl/bbt_walker.sv
module bbt_walker
    import bbt_pkg::*;
#(
    parameter int NUM_BLOCKS    = 512,
    parameter int PAGES_PER_BLK = 16,
    parameter int COL_W         = 10,
    parameter int MARK_COL      = 517
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic                                           start_i,
    input  logic                                           rd_ack_i,
    input  logic [7:0]                                     rd_data_i,
    output logic                                           busy_o,
    output logic                                           done_o,
    output logic                                           rd_req_o,
    output logic [$clog2(NUM_BLOCKS)+$clog2(PAGES_PER_BLK)-1:0] rd_row_o,
    output logic [COL_W-1:0]                               rd_col_o,
    output logic                                           clr_o,
    output logic                                           set_o,
    output logic [$clog2(NUM_BLOCKS)-1:0]                  set_idx_o
);
    localparam int BLK_W = $clog2(NUM_BLOCKS);
    localparam int PG_W  = $clog2(PAGES_PER_BLK);
    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);
    localparam logic [PG_W-1:0]  PG_SECOND = PG_W'(1);

    typedef struct packed {
        walk_st_t         st;
        logic [BLK_W-1:0] blk;
        logic [PG_W-1:0]  pg;
        logic             done;
    } walk_t;

    walk_t r_d, r_q;
    logic  mark_bad;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        clr_o    = 1'b0;
        set_o    = 1'b0;
        mark_bad = (rd_data_i != ERASED_BYTE);
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    clr_o  = 1'b1;
                    r_d.st = ST_READ;
                    r_d.blk = BLK_W'(1);
                    r_d.pg = '0;
                end
            end
            ST_READ: begin
                if (rd_ack_i) begin
                    if (mark_bad) set_o = 1'b1;
                    if (mark_bad || (r_q.pg == PG_SECOND)) begin
                        r_d.pg = '0;
                        if (r_q.blk == LAST_BLK) begin
                            r_d.st   = ST_IDLE;
                            r_d.done = 1'b1;
                        end else begin
                            r_d.blk = r_q.blk + BLK_W'(1);
                        end
                    end else begin
                        r_d.pg = PG_SECOND;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, blk: '0, pg: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o    = (r_q.st == ST_READ);
    assign done_o    = r_q.done;
    assign rd_req_o  = (r_q.st == ST_READ);
    assign rd_row_o  = {r_q.blk, r_q.pg};
    assign rd_col_o  = COL_W'(MARK_COL);
    assign set_idx_o = r_q.blk;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_row_o)); // R6
    AST_NO_BLK0: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (rd_row_o[BLK_W+PG_W-1:PG_W] != '0)); // R2
    AST_PAGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (rd_row_o[PG_W-1:0] <= PG_SECOND)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i && !rd_ack_i |=> busy_o); // R9
endmodule

// File: rtl/bbt_bitmap.sv
module bbt_bitmap #(
    parameter int NUM_BLOCKS = 512,
    parameter int CNT_W      = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr_i,
    input  logic                          set_i,
    input  logic [$clog2(NUM_BLOCKS)-1:0] set_idx_i,
    input  logic [$clog2(NUM_BLOCKS)-1:0] q_idx_i,
    output logic                          q_bad_o,
    output logic [CNT_W-1:0]              cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [NUM_BLOCKS-1:0] tbl_d, tbl_q;
    logic [CNT_W-1:0]      cnt_d, cnt_q;

    always_comb begin
        tbl_d = tbl_q;
        cnt_d = cnt_q;
        if (clr_i) begin
            tbl_d = '0;
            cnt_d = '0;
        end else if (set_i) begin
            tbl_d[set_idx_i] = 1'b1;
            if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
            cnt_q <= '0;
        end else begin
            tbl_q <= tbl_d;
            cnt_q <= cnt_d;
        end
    end

    assign q_bad_o = tbl_q[q_idx_i];
    assign cnt_o   = cnt_q;

    AST_CNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> cnt_o >= $past(cnt_o)); // R8
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_o == '0); // R1
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i && !set_i |=> $stable(cnt_o)); // R7
endmodule

// File: rtl/bbt_builder.sv
module bbt_builder #(
    parameter int NUM_BLOCKS    = 512,
    parameter int PAGES_PER_BLK = 16,
    parameter int COL_W         = 10,
    parameter int SPARE_BASE    = 512,
    parameter int MARK_OFS      = 5,
    parameter int CNT_W         = 10
) (
    input  logic                                                clk,
    input  logic                                                rst_n,
    input  logic                                                start_i,
    output logic                                                busy_o,
    output logic                                                done_o,
    output logic                                                rd_req_o,
    output logic [$clog2(NUM_BLOCKS)+$clog2(PAGES_PER_BLK)-1:0] rd_row_o,
    output logic [COL_W-1:0]                                    rd_col_o,
    input  logic                                                rd_ack_i,
    input  logic [7:0]                                          rd_data_i,
    input  logic [$clog2(NUM_BLOCKS)-1:0]                       q_blk_i,
    output logic                                                q_bad_o,
    output logic [CNT_W-1:0]                                    bad_cnt_o
);
    localparam int BLK_W    = $clog2(NUM_BLOCKS);
    localparam int MARK_COL = SPARE_BASE + MARK_OFS;

    logic             clr_w, set_w;
    logic [BLK_W-1:0] set_idx_w;

    bbt_walker #(
        .NUM_BLOCKS   (NUM_BLOCKS),
        .PAGES_PER_BLK(PAGES_PER_BLK),
        .COL_W        (COL_W),
        .MARK_COL     (MARK_COL)
    ) walker_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .rd_ack_i (rd_ack_i),
        .rd_data_i(rd_data_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .rd_req_o (rd_req_o),
        .rd_row_o (rd_row_o),
        .rd_col_o (rd_col_o),
        .clr_o    (clr_w),
        .set_o    (set_w),
        .set_idx_o(set_idx_w)
    );

    bbt_bitmap #(
        .NUM_BLOCKS(NUM_BLOCKS),
        .CNT_W     (CNT_W)
    ) bitmap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr_w),
        .set_i    (set_w),
        .set_idx_i(set_idx_w),
        .q_idx_i  (q_blk_i),
        .q_bad_o  (q_bad_o),
        .cnt_o    (bad_cnt_o)
    );
endmodule

// File: tb/bbt_builder_tb_top.sv
module bbt_builder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        busy_o, done_o, rd_req_o, rd_ack_i, q_bad_o;
    logic [12:0] rd_row_o;
    logic [9:0]  rd_col_o, bad_cnt_o;
    logic [7:0]  rd_data_i;
    logic [8:0]  q_blk_i;

    int n_checks = 0;
    int n_fails  = 0;
    int latency  = 0;
    int wait_cnt = 0;
    int done_seen = 0;
    logic [7:0] mark_p0 [NB];
    logic [7:0] mark_p1 [NB];
    int exp_rows [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bbt_builder dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
        .rd_req_o(rd_req_o), .rd_row_o(rd_row_o), .rd_col_o(rd_col_o),
        .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .q_blk_i(q_blk_i),
        .q_bad_o(q_bad_o), .bad_cnt_o(bad_cnt_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: expected read sequence from the requirements (R2, R3, R4, R5)
    task automatic push_expected();
        exp_rows.delete();
        for (int b = 1; b < NB; b++) begin
            exp_rows.push_back(b * 16);
            if (mark_p0[b] == 8'hFF) exp_rows.push_back(b * 16 + 1);
        end
    endtask

    function automatic bit exp_bad(input int b);
        if (b == 0) return 1'b0;
        return (mark_p0[b] != 8'hFF) || (mark_p1[b] != 8'hFF);
    endfunction

    // Monitor / responder: pops each expected read and serves it
    initial begin
        rd_ack_i = 1'b0;
        rd_data_i = 8'h00;
        forever begin
            @(negedge clk);
            if (rd_ack_i) begin
                rd_ack_i = 1'b0;
            end else if (rd_req_o) begin
                if (wait_cnt > 0) begin
                    wait_cnt--;
                end else begin
                    int blk, pg, er;
                    blk = int'(rd_row_o) / 16;
                    pg  = int'(rd_row_o) % 16;
                    if (exp_rows.size() == 0) begin
                        chk(1'b0, "R3 unexpected read", int'(rd_row_o), -1);
                    end else begin
                        er = exp_rows.pop_front();
                        chk(int'(rd_row_o) == er, "R3 read row", int'(rd_row_o), er);
                    end
                    chk(rd_col_o == 10'd517, "R3 read column", int'(rd_col_o), 517);
                    chk(blk != 0, "R2 block 0 read", blk, 1);
                    rd_data_i = (pg == 0) ? mark_p0[blk] : (pg == 1) ? mark_p1[blk] : 8'hFF;
                    rd_ack_i = 1'b1;
                    wait_cnt = latency;
                end
            end
        end
    end

    always @(negedge clk) if (done_o) done_seen++;

    task automatic check_table(input string tag);
        int exp_cnt = 0;
        for (int b = 0; b < NB; b++) begin
            q_blk_i = 9'(b);
            #1;
            if (exp_bad(b)) exp_cnt++;
            if (q_bad_o !== exp_bad(b)) chk(1'b0, "R10 table bit", int'(q_bad_o), int'(exp_bad(b)));
        end
        n_checks++;
        chk(int'(bad_cnt_o) == exp_cnt, "R8 bad count", int'(bad_cnt_o), exp_cnt);
        q_blk_i = 9'd0; #1;
        chk(q_bad_o == 1'b0, "R2 block 0 good", int'(q_bad_o), 0);
        $display("%s table checked, %0d bad", tag, exp_cnt);
    endtask

    task automatic run_scan(input int lat, input bit poke_start);
        int guard = 0;
        int cnt_hold;
        latency = lat;
        wait_cnt = lat;
        done_seen = 0;
        push_expected();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R1 busy after start", int'(busy_o), 1);
        chk(bad_cnt_o == 10'd0, "R1 count cleared", int'(bad_cnt_o), 0);
        q_blk_i = 9'd300; #1;
        chk(q_bad_o == 1'b0, "R1 table cleared", int'(q_bad_o), 0);
        if (poke_start) begin
            repeat (20) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk(busy_o == 1'b1, "R9 busy kept", int'(busy_o), 1);
        end
        while (!done_o && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 20000) begin
            chk(1'b0, "R7 watchdog expired", 0, 1);
            return;
        end
        chk(busy_o == 1'b0, "R7 busy falls with done", int'(busy_o), 0);
        chk(exp_rows.size() == 0, "R3 all reads issued", exp_rows.size(), 0);
        cnt_hold = int'(bad_cnt_o);
        @(negedge clk);
        chk(done_o == 1'b0, "R7 done one cycle", int'(done_o), 0);
        repeat (5) @(negedge clk);
        chk(int'(bad_cnt_o) == cnt_hold, "R7 count held", int'(bad_cnt_o), cnt_hold);
        chk(done_seen == 1, "R9 single done pulse", done_seen, 1);
        chk(rd_req_o == 1'b0, "R7 no read after done", int'(rd_req_o), 0);
    endtask

    initial begin
        q_blk_i = 9'd0;
        for (int b = 0; b < NB; b++) begin
            mark_p0[b] = 8'hFF;
            mark_p1[b] = 8'hFF;
        end
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(busy_o == 1'b0 && done_o == 1'b0 && rd_req_o == 1'b0, "R11 reset outputs",
            int'({busy_o, done_o, rd_req_o}), 0);
        chk(bad_cnt_o == 10'd0, "R11 reset count", int'(bad_cnt_o), 0);
        q_blk_i = 9'd7; #1;
        chk(q_bad_o == 1'b0, "R11 reset table", int'(q_bad_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0, "R11 idle without start", int'(busy_o), 0);

        // Scan 1: clean array, zero latency (R3, R5)
        run_scan(0, 1'b0);
        check_table("clean");

        // Scan 2: mixed marks (R2, R4, R5, R9), latency 1
        mark_p0[0]   = 8'h00;
        mark_p1[0]   = 8'h00;
        mark_p0[1]   = 8'h00;
        mark_p1[2]   = 8'hFE;
        mark_p0[3]   = 8'h7F;
        mark_p1[3]   = 8'h00;
        mark_p0[100] = 8'hFE;
        mark_p1[255] = 8'h7F;
        mark_p0[256] = 8'h01;
        mark_p1[400] = 8'h00;
        for (int b = 480; b < 490; b++) mark_p1[b] = 8'h55;
        mark_p0[511] = 8'h00;
        run_scan(1, 1'b1);
        check_table("mixed");
        chk(bad_cnt_o == 10'd18, "R8 mixed count", int'(bad_cnt_o), 18);

        // Scan 3: clean again, latency 2; table must be cleared (R1)
        for (int b = 0; b < NB; b++) begin
            mark_p0[b] = 8'hFF;
            mark_p1[b] = 8'hFF;
        end
        mark_p1[511] = 8'h00;
        run_scan(2, 1'b0);
        check_table("rescan");
        chk(bad_cnt_o == 10'd1, "R8 rescan count", int'(bad_cnt_o), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        n_checks++;
        n_fails++;
        $display("FAIL R7 global watchdog: actual 0 expected 1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule